// File: doc/BRIEF.md
# Single-Pin Drive and Sense Unit

This block carries out one-pin I/O instructions for a core that owns 128 I/O pins. Each pin has an output-level bit and a drive-enable bit, held in two 128-bit vectors. A write instruction names one pin and a 3-bit sub-operation. It always rewrites both bits of that pin in the same cycle. The new output level is a constant, the inverse of the present level, or the core's carry or zero flag, taken true or inverted.

The unit also runs two sense instructions. Each samples the level of one pin and returns it to the flag logic as zero and carry results. Each flag result has its own write enable. The pin number comes either from an immediate field or from the low bits of a register value. Both vectors are available whole, and also through a 32-bit bank window for word-wide readers.

Top module: `pinio_unit`

## Requirements
- R1: After reset every output-level and drive-enable bit is 0, and neither flag write enable is active.
- R2: A write with sub-operation 3'b000 clears both the output-level bit and the drive-enable bit of the addressed pin.
- R3: Sub-operations 3'b001, 3'b010 and 3'b011 invert, clear and set the output-level bit respectively, and each sets the drive-enable bit to 1.
- R4: Sub-operations 3'b100, 3'b101, 3'b110 and 3'b111 load the output-level bit with C, inverted C, Z and inverted Z respectively, and each sets the drive-enable bit to 1.
- R5: A write takes effect at the first clock edge after the strobe. Pins other than the addressed one keep both bits. Without a strobe, nothing changes.
- R6: When `src_imm` is 1 the pin number is `imm_pin`. Otherwise it is `reg_val[6:0]`, and the higher register bits have no effect.
- R7: A sense with `exec_sub[0]`=0 returns the inverted pin level as Z and the true level as C. A sense with `exec_sub[0]`=1 returns the true level as Z and the inverted level as C. A sense leaves both vectors unchanged.
- R8: The Z and C results are presented, with `z_we`/`c_we` high, in the cycle after a sense strobe, only when `wz_en`/`wc_en` was set. The enables are low in every other cycle.
- R9: `out_bank` and `dir_bank` show bits 32k to 32k+31 of the output-level and drive-enable vectors, where k is `bank_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exec_vld | input | 1 | Execute strobe for one instruction |
| exec_rd | input | 1 | 1 = sense instruction, 0 = write instruction |
| exec_sub | input | 3 | Write sub-operation; bit 0 selects the inverted sense |
| src_imm | input | 1 | 1 = pin from `imm_pin`, 0 = pin from `reg_val` |
| imm_pin | input | 7 | Immediate pin number |
| reg_val | input | 32 | Register operand holding a pin number in its low bits |
| flag_c | input | 1 | Core carry flag |
| flag_z | input | 1 | Core zero flag |
| wz_en | input | 1 | Write enable for the zero result |
| wc_en | input | 1 | Write enable for the carry result |
| pins_in | input | 128 | Sampled pin levels |
| bank_sel | input | 2 | Bank selected for the word views |
| out_vec | output | 128 | Output-level bits |
| dir_vec | output | 128 | Drive-enable bits |
| out_bank | output | 32 | Selected 32-bit bank of output levels |
| dir_bank | output | 32 | Selected 32-bit bank of drive enables |
| z_we | output | 1 | Zero result valid |
| z_val | output | 1 | Zero result |
| c_we | output | 1 | Carry result valid |
| c_val | output | 1 | Carry result |

## Verification
The case that is hardest to reach is a write that lands on a pin whose neighbours already hold a mix of levels and enables. That is the only way to show that only one bit pair moves. A sweep that starts from zero cannot show it. The stimulus therefore walks every pin through all eight sub-operations in turn, with the flags changing from step to step. Each result is compared against the full 128-bit vectors, which by then carry the history of every earlier step. Odd pins are addressed through the register operand with junk in its upper bits, so the register path is exercised in the same sweep.

// File: rtl/pinio_pkg.sv
package pinio_pkg;

    typedef enum logic [2:0] {
        SUB_OFF  = 3'b000,
        SUB_INV  = 3'b001,
        SUB_LOW  = 3'b010,
        SUB_HIGH = 3'b011,
        SUB_C    = 3'b100,
        SUB_NC   = 3'b101,
        SUB_Z    = 3'b110,
        SUB_NZ   = 3'b111
    } pin_sub_e;

    localparam int unsigned DEF_NPINS  = 128;
    localparam int unsigned DEF_BANK_W = 32;
    localparam int unsigned DEF_REG_W  = 32;

endpackage

// File: rtl/pinio_index_sel.sv
module pinio_index_sel #(
    parameter int unsigned PIN_W = 7,
    parameter int unsigned REG_W = 32
) (
    input  logic             src_imm,
    input  logic [PIN_W-1:0] imm_pin,
    input  logic [REG_W-1:0] reg_val,
    output logic [PIN_W-1:0] pin_idx
);

    // Only the low PIN_W bits of the register operand select a pin.
    always_comb begin
        if (src_imm) begin
            pin_idx = imm_pin;
        end else begin
            pin_idx = reg_val[PIN_W-1:0];
        end
    end

endmodule

// File: rtl/pinio_bit_calc.sv
module pinio_bit_calc
    import pinio_pkg::*;
(
    input  logic [2:0] sub_op,
    input  logic       cur_out,
    input  logic       flag_c,
    input  logic       flag_z,
    output logic       new_out,
    output logic       new_dir
);

    always_comb begin
        new_dir = 1'b1;
        unique case (pin_sub_e'(sub_op))
            SUB_OFF: begin
                new_out = 1'b0;
                new_dir = 1'b0;
            end
            SUB_INV:  new_out = ~cur_out;
            SUB_LOW:  new_out = 1'b0;
            SUB_HIGH: new_out = 1'b1;
            SUB_C:    new_out = flag_c;
            SUB_NC:   new_out = ~flag_c;
            SUB_Z:    new_out = flag_z;
            SUB_NZ:   new_out = ~flag_z;
            default:  new_out = 1'b0;
        endcase
    end

endmodule

// File: rtl/pinio_flag_read.sv
module pinio_flag_read (
    input  logic act,
    input  logic inv_sel,
    input  logic level,
    input  logic wz_en,
    input  logic wc_en,
    output logic z_we,
    output logic z_val,
    output logic c_we,
    output logic c_val
);

    always_comb begin
        z_we  = act & wz_en;
        c_we  = act & wc_en;
        z_val = act & (inv_sel ? level : ~level);
        c_val = act & (inv_sel ? ~level : level);
    end

endmodule

// File: rtl/pinio_bank_view.sv
module pinio_bank_view #(
    parameter int unsigned NPINS  = 128,
    parameter int unsigned BANK_W = 32,
    localparam int unsigned NBANKS = NPINS / BANK_W,
    localparam int unsigned BSEL_W = (NBANKS > 1) ? $clog2(NBANKS) : 1
) (
    input  logic [NPINS-1:0]  vec,
    input  logic [BSEL_W-1:0] sel,
    output logic [BANK_W-1:0] bank
);

    logic [BANK_W-1:0] slices [NBANKS];

    for (genvar g = 0; g < NBANKS; g++) begin : g_slice
        assign slices[g] = vec[g*BANK_W +: BANK_W];
    end

    always_comb begin
        bank = '0;
        for (int k = 0; k < NBANKS; k++) begin
            if (BSEL_W'(k) == sel) begin
                bank = slices[k];
            end
        end
    end

endmodule

// File: rtl/pinio_unit.sv
module pinio_unit
    import pinio_pkg::*;
#(
    parameter int unsigned NPINS  = DEF_NPINS,
    parameter int unsigned BANK_W = DEF_BANK_W,
    parameter int unsigned REG_W  = DEF_REG_W,
    localparam int unsigned PIN_W  = $clog2(NPINS),
    localparam int unsigned NBANKS = NPINS / BANK_W,
    localparam int unsigned BSEL_W = (NBANKS > 1) ? $clog2(NBANKS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exec_vld,
    input  logic              exec_rd,
    input  logic [2:0]        exec_sub,
    input  logic              src_imm,
    input  logic [PIN_W-1:0]  imm_pin,
    input  logic [REG_W-1:0]  reg_val,
    input  logic              flag_c,
    input  logic              flag_z,
    input  logic              wz_en,
    input  logic              wc_en,
    input  logic [NPINS-1:0]  pins_in,
    input  logic [BSEL_W-1:0] bank_sel,
    output logic [NPINS-1:0]  out_vec,
    output logic [NPINS-1:0]  dir_vec,
    output logic [BANK_W-1:0] out_bank,
    output logic [BANK_W-1:0] dir_bank,
    output logic              z_we,
    output logic              z_val,
    output logic              c_we,
    output logic              c_val
);

    typedef struct packed {
        logic [NPINS-1:0] outs;
        logic [NPINS-1:0] dirs;
        logic             zwe;
        logic             zv;
        logic             cwe;
        logic             cv;
    } state_t;

    state_t st_d, st_q;

    logic [PIN_W-1:0] pin_idx;
    logic             cur_out;
    logic             pin_level;
    logic             new_out;
    logic             new_dir;
    logic             rd_act;
    logic             fz_we, fz_val, fc_we, fc_val;

    pinio_index_sel #(.PIN_W(PIN_W), .REG_W(REG_W)) u_idx (
        .src_imm (src_imm),
        .imm_pin (imm_pin),
        .reg_val (reg_val),
        .pin_idx (pin_idx)
    );

    assign cur_out   = st_q.outs[pin_idx];
    assign pin_level = pins_in[pin_idx];
    assign rd_act    = exec_vld & exec_rd;

    pinio_bit_calc u_calc (
        .sub_op  (exec_sub),
        .cur_out (cur_out),
        .flag_c  (flag_c),
        .flag_z  (flag_z),
        .new_out (new_out),
        .new_dir (new_dir)
    );

    pinio_flag_read u_rd (
        .act     (rd_act),
        .inv_sel (exec_sub[0]),
        .level   (pin_level),
        .wz_en   (wz_en),
        .wc_en   (wc_en),
        .z_we    (fz_we),
        .z_val   (fz_val),
        .c_we    (fc_we),
        .c_val   (fc_val)
    );

    always_comb begin
        st_d     = st_q;
        st_d.zwe = fz_we;
        st_d.zv  = fz_val;
        st_d.cwe = fc_we;
        st_d.cv  = fc_val;
        if (exec_vld && !exec_rd) begin
            st_d.outs[pin_idx] = new_out;
            st_d.dirs[pin_idx] = new_dir;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_vec = st_q.outs;
    assign dir_vec = st_q.dirs;
    assign z_we    = st_q.zwe;
    assign z_val   = st_q.zv;
    assign c_we    = st_q.cwe;
    assign c_val   = st_q.cv;

    pinio_bank_view #(.NPINS(NPINS), .BANK_W(BANK_W)) u_obank (
        .vec  (st_q.outs),
        .sel  (bank_sel),
        .bank (out_bank)
    );

    pinio_bank_view #(.NPINS(NPINS), .BANK_W(BANK_W)) u_dbank (
        .vec  (st_q.dirs),
        .sel  (bank_sel),
        .bank (dir_bank)
    );

endmodule

// File: rtl/pinio_unit_chk.sv
module pinio_unit_chk #(
    parameter int unsigned NPINS = 128,
    localparam int unsigned PIN_W = $clog2(NPINS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             exec_vld,
    input logic             exec_rd,
    input logic [2:0]       exec_sub,
    input logic             src_imm,
    input logic [PIN_W-1:0] imm_pin,
    input logic [NPINS-1:0] out_vec,
    input logic [NPINS-1:0] dir_vec,
    input logic             z_we,
    input logic             z_val,
    input logic             c_we,
    input logic             c_val
);

    // R5: no strobe, no state change
    a_r5_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_vld |=> ($stable(out_vec) && $stable(dir_vec)));

    // R7: a sense leaves both vectors alone
    a_r7_sense_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_vld && exec_rd) |=> ($stable(out_vec) && $stable(dir_vec)));

    // R8: flag enables only follow a sense strobe
    a_r8_no_stray_we: assert property (@(posedge clk) disable iff (!rst_n)
        !(exec_vld && exec_rd) |=> (!z_we && !c_we));

    // R7: both results present means they are complements
    a_r7_complement: assert property (@(posedge clk) disable iff (!rst_n)
        (z_we && c_we) |-> (z_val != c_val));

    // R2: the off operation leaves the pin undriven and low
    a_r2_off: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_vld && !exec_rd && src_imm && exec_sub == 3'b000)
        |=> (!out_vec[$past(imm_pin)] && !dir_vec[$past(imm_pin)]));

    // R3, R4: every other write leaves the pin driven
    a_r3_r4_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_vld && !exec_rd && src_imm && exec_sub != 3'b000)
        |=> dir_vec[$past(imm_pin)]);

endmodule

bind pinio_unit pinio_unit_chk #(.NPINS(NPINS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .exec_vld (exec_vld),
    .exec_rd  (exec_rd),
    .exec_sub (exec_sub),
    .src_imm  (src_imm),
    .imm_pin  (imm_pin),
    .out_vec  (out_vec),
    .dir_vec  (dir_vec),
    .z_we     (z_we),
    .z_val    (z_val),
    .c_we     (c_we),
    .c_val    (c_val)
);

// File: tb/pinio_unit_tb.sv
module pinio_unit_tb;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         exec_vld = 1'b0;
    logic         exec_rd = 1'b0;
    logic [2:0]   exec_sub = '0;
    logic         src_imm = 1'b1;
    logic [6:0]   imm_pin = '0;
    logic [31:0]  reg_val = '0;
    logic         flag_c = 1'b0;
    logic         flag_z = 1'b0;
    logic         wz_en = 1'b0;
    logic         wc_en = 1'b0;
    logic [127:0] pins_in = '0;
    logic [1:0]   bank_sel = '0;
    logic [127:0] out_vec, dir_vec;
    logic [31:0]  out_bank, dir_bank;
    logic         z_we, z_val, c_we, c_val;

    int checks = 0;
    int errors = 0;
    logic [127:0] m_out = '0;
    logic [127:0] m_dir = '0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    pinio_unit u_dut (
        .clk(clk), .rst_n(rst_n), .exec_vld(exec_vld), .exec_rd(exec_rd),
        .exec_sub(exec_sub), .src_imm(src_imm), .imm_pin(imm_pin),
        .reg_val(reg_val), .flag_c(flag_c), .flag_z(flag_z), .wz_en(wz_en),
        .wc_en(wc_en), .pins_in(pins_in), .bank_sel(bank_sel),
        .out_vec(out_vec), .dir_vec(dir_vec), .out_bank(out_bank),
        .dir_bank(dir_bank), .z_we(z_we), .z_val(z_val), .c_we(c_we),
        .c_val(c_val)
    );

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_vecs(input string req);
        chk({req, " out"}, out_vec, m_out);
        chk({req, " dir"}, dir_vec, m_dir);
    endtask

    // Drive one instruction for one cycle; results are visible at the next negedge.
    task automatic issue(input logic rd, input logic [2:0] sub, input int pin,
                         input logic use_reg, input logic c, input logic z);
        @(negedge clk);
        exec_vld = 1'b1;
        exec_rd  = rd;
        exec_sub = sub;
        flag_c   = c;
        flag_z   = z;
        if (use_reg) begin
            src_imm = 1'b0;
            imm_pin = 7'(~pin);
            reg_val = {25'h15A_C3E ^ 25'(pin), 7'(pin)};
        end else begin
            src_imm = 1'b1;
            imm_pin = 7'(pin);
            reg_val = 32'hFFFF_FF80 | 32'(~pin & 7'h7F);
        end
        @(negedge clk);
        exec_vld = 1'b0;
    endtask

    function automatic logic model_bit(input logic [2:0] sub, input logic cur,
                                       input logic c, input logic z);
        case (sub)
            3'd0: return 1'b0;
            3'd1: return ~cur;
            3'd2: return 1'b0;
            3'd3: return 1'b1;
            3'd4: return c;
            3'd5: return ~c;
            3'd6: return z;
            default: return ~z;
        endcase
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 reset", {out_vec ^ 128'd0}, 128'd0);
        chk("R1 reset dir", dir_vec, 128'd0);
        chk("R1 reset we", {126'd0, z_we, c_we}, 128'd0);

        // R2 R3 R4 R5 R6: every pin, every sub-operation, changing flags
        for (int p = 0; p < 128; p++) begin
            for (int s = 0; s < 8; s++) begin
                logic c, z;
                c = 1'((p + s) >> 1);
                z = 1'((p * 3 + s) >> 2);
                issue(1'b0, 3'(s), p, p[0], c, z);
                m_out[p] = model_bit(3'(s), m_out[p], c, z);
                m_dir[p] = (s != 0);
                if (s == 0) chk_vecs("R2 off");
                else if (s < 4) chk_vecs(p[0] ? "R3 R6 reg" : "R3 imm");
                else chk_vecs(p[0] ? "R4 R6 reg" : "R4 R5 imm");
            end
            // leave a varied pattern behind for later pins
            issue(1'b0, 3'(3 - (p % 3)), p, 1'b0, 1'b0, 1'b0);
            m_out[p] = (p % 3 == 0);
            m_dir[p] = 1'b1;
            if (p % 3 == 2) begin
                issue(1'b0, 3'd0, p, 1'b0, 1'b0, 1'b0);
                m_out[p] = 1'b0;
                m_dir[p] = 1'b0;
            end
            chk_vecs("R5 pattern");
        end

        // R9: bank views
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            bank_sel = 2'(k);
            #1;
            chk("R9 out bank", {96'd0, out_bank}, {96'd0, m_out[k*32 +: 32]});
            chk("R9 dir bank", {96'd0, dir_bank}, {96'd0, m_dir[k*32 +: 32]});
        end

        // R5: no strobe means no change, whatever the other inputs do
        @(negedge clk);
        exec_sub = 3'd3; imm_pin = 7'd2; src_imm = 1'b1; exec_rd = 1'b0;
        repeat (3) @(negedge clk);
        chk_vecs("R5 idle");

        // R7 R8: sense sweep
        pins_in = {32'hC3A5_0F69, 32'h1234_FEDC, 32'h8001_7FFE, 32'h5A5A_0FF0};
        for (int p = 0; p < 128; p++) begin
            for (int m = 0; m < 8; m++) begin
                logic inv, ez, ec, lvl;
                inv = m[0];
                ez  = m[1];
                ec  = m[2];
                lvl = pins_in[p];
                @(negedge clk);
                wz_en = ez;
                wc_en = ec;
                issue(1'b1, {2'(p), inv}, p, p[1], 1'b0, 1'b0);
                chk("R8 z_we", {127'd0, z_we}, {127'd0, ez});
                chk("R8 c_we", {127'd0, c_we}, {127'd0, ec});
                if (ez) chk("R7 z_val", {127'd0, z_val}, {127'd0, inv ? lvl : ~lvl});
                if (ec) chk("R7 c_val", {127'd0, c_val}, {127'd0, inv ? ~lvl : lvl});
                if (p % 32 == 5) chk_vecs("R7 sense keeps");
            end
        end
        @(negedge clk);
        chk("R8 we idle", {126'd0, z_we, c_we}, 128'd0);
        chk_vecs("R7 final");

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule